// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 64K words by 16 bits that has one active-low enable per byte lane. The host offers a request on a valid/ready port. A request carries a word address, write data, a per-lane mask and a direction flag. The controller turns each accepted request into one access cycle on the RAM pins. It drives chip select, output enable, write enable, the two lane enables and the address. The data bus is split into an output value, an output-enable and an input value, so that the pad ring can build the tristate.

Every analog timing window of the RAM is held as a minimum number of system-clock cycles. Each count is the nanosecond figure divided by the clock period and rounded up, and no phase is shorter than one cycle. An access runs through a setup phase, then either a read-access phase or a write-pulse phase, then a recovery phase with every strobe inactive. The write data is put on the bus only after the release window that follows the fall of write enable. The result comes back as a one-cycle done pulse. For a read, the captured word comes back with that pulse.

With the default parameters (5 ns clock, 55 ns grade), the phase lengths are as follows. Setup lasts 1 cycle. Read access lasts 10 cycles. The write pulse lasts 9 cycles, and the bus is driven from its 5th cycle. Recovery lasts 4 cycles.

Top module: `sramCtl`

## Requirements
- R1: Reset and idle state. Chip select, output enable, write enable and both lane enables are high, the bus output-enable is low and `reqReady` is high. `rspDone` is low while no response is due.
- R2: A request is accepted in a cycle where `reqValid` and `reqReady` are both high. If its mask is non-zero, `reqReady` is low from the next cycle through the last recovery cycle. With defaults that is 15 cycles for a read and 14 for a write.
- R3: A read holds chip select low for the setup and access phases, with the request address on `sramAddr` throughout. Output enable is high during setup and low for the whole access phase. Write enable stays high.
- R4: Read data is taken from `sramDqIn` at the clock edge that ends the last access cycle. Lanes whose mask bit is 0 read as zero. The word appears on `rspRdata` with a one-cycle `rspDone`, in the cycle after recovery ends.
- R5: A write holds chip select low for setup and pulse. Write enable is low for exactly the pulse phase, and output enable stays high for the whole request.
- R6: `sramDqOe` is high only while write enable is low and output enable is high. It rises once the release window after the fall of write enable has passed, and it stays high until the cycle in which write enable rises. `sramDqOut` then carries the request's write data.
- R7: Mask bit 0 selects data bits 7:0 through `sramBeN[0]`, and mask bit 1 selects bits 15:8 through `sramBeN[1]` (low = enabled). A lane enable is low only while chip select is low and its mask bit is set. A write to one lane leaves the other lane of that word unchanged.
- R8: Every access ends with a recovery phase in which all strobes are high and the bus is not driven. The phase lasts at least as long as the bus-release window and fills out the minimum cycle time.
- R9: A request with mask 0 pulses no strobe and never leaves idle, whatever its direction. `rspDone` is high in the next cycle with `rspRdata` zero, and `reqReady` stays high. A write of this kind changes no memory word.
- R10: A completed write returns `rspRdata` equal to zero with its done pulse.
- R11: Output enable and write enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | 16 | Word address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| reqWdata | input | 16 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read result, valid with rspDone |
| sramCeN | output | 1 | RAM chip select, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramBeN | output | 2 | RAM lane enables, active low, bit 0 = lower lane |
| sramAddr | output | 16 | RAM address |
| sramDqOut | output | 16 | Value for the data pads when driven |
| sramDqOe | output | 1 | Data pad output enable |
| sramDqIn | input | 16 | Value seen on the data pads |

## Verification
The bench puts a RAM model on the pins. The model returns inverted, wrong data until output enable has been low for the full access count. A controller that samples one cycle early therefore returns a corrupt word. Single-lane reads see junk on the unselected lane, which catches missing lane masking. A single-lane write followed by a full read shows whether the other byte was overwritten. Zero-mask reads and writes are issued between real accesses, and a read-back of the target word exposes any stray strobe. Back-to-back requests with `reqValid` held high check that the controller waits through recovery, does not accept early, and never drives the bus during a read.

// File: rtl/sramCtlPkg.sv
package sramCtlPkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_ACC   = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_RECOVER  = 3'd4
  } ctlState_e;

  // Strobe intent for the next cycle, registered by the datapath
  typedef struct packed {
    logic chipSel;
    logic outEn;
    logic wrEn;
    logic drive;
  } strobe_t;

  // One-cycle commands from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic done;
  } pathCmd_t;

  function automatic int ceilCyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int maxI(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramCtlSeq.sv
module sramCtlSeq
  import sramCtlPkg::*;
#(
  parameter int LANES        = 2,
  parameter int CLK_NS       = 5,
  parameter int T_ADDR_SU_NS = 0,
  parameter int T_WE_PW_NS   = 40,
  parameter int T_AW_NS      = 45,
  parameter int T_DSU_NS     = 25,
  parameter int T_WC_NS      = 55,
  parameter int T_RC_NS      = 55,
  parameter int T_AA_NS      = 55,
  parameter int T_DOE_NS     = 25,
  parameter int T_DBE_NS     = 55,
  parameter int T_RELEASE_NS = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output strobe_t          stbNext,
  output pathCmd_t         cmd
);

  // Cycle counts derived from the nanosecond windows
  localparam int SU_CYC  = maxI(1, ceilCyc(T_ADDR_SU_NS, CLK_NS));
  localparam int REL_CYC = ceilCyc(T_RELEASE_NS, CLK_NS);
  localparam int PW_CYC  = maxI(maxI(1, ceilCyc(T_WE_PW_NS, CLK_NS)),
                                maxI(ceilCyc(T_AW_NS, CLK_NS) - SU_CYC,
                                     REL_CYC + maxI(1, ceilCyc(T_DSU_NS, CLK_NS))));
  localparam int ACC_CYC = maxI(maxI(1, ceilCyc(T_DOE_NS, CLK_NS)),
                                maxI(ceilCyc(T_AA_NS, CLK_NS), ceilCyc(T_DBE_NS, CLK_NS)) - SU_CYC);
  localparam int REC_CYC = maxI(maxI(1, REL_CYC),
                                maxI(ceilCyc(T_WC_NS, CLK_NS) - SU_CYC - PW_CYC,
                                     ceilCyc(T_RC_NS, CLK_NS) - SU_CYC - ACC_CYC));
  localparam int MAX_LEN = maxI(maxI(SU_CYC, PW_CYC), maxI(ACC_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  ctlState_e        state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt, lenM1;
  logic             lastCyc;
  logic             opWriteQ;
  logic             maskAny;
  logic             accept;

  assign maskAny  = |reqMask;
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    case (state)
      ST_SETUP:    lenM1 = CNT_W'(SU_CYC - 1);
      ST_RD_ACC:   lenM1 = CNT_W'(ACC_CYC - 1);
      ST_WR_PULSE: lenM1 = CNT_W'(PW_CYC - 1);
      ST_RECOVER:  lenM1 = CNT_W'(REC_CYC - 1);
      default:     lenM1 = '0;
    endcase
  end

  assign lastCyc = (cnt == lenM1);

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:     if (accept && maskAny) nxtState = ST_SETUP;
      ST_SETUP:    if (lastCyc) nxtState = opWriteQ ? ST_WR_PULSE : ST_RD_ACC;
      ST_RD_ACC:   if (lastCyc) nxtState = ST_RECOVER;
      ST_WR_PULSE: if (lastCyc) nxtState = ST_RECOVER;
      ST_RECOVER:  if (lastCyc) nxtState = ST_IDLE;
      default:     nxtState = ST_IDLE;
    endcase
  end

  assign nxtCnt = (nxtState != state || state == ST_IDLE) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      opWriteQ <= 1'b0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
      if (accept) opWriteQ <= reqWrite;
    end
  end

  // Strobe intent for the state entered at the next edge
  always_comb begin
    stbNext.chipSel = (nxtState == ST_SETUP) || (nxtState == ST_RD_ACC) ||
                      (nxtState == ST_WR_PULSE);
    stbNext.outEn   = (nxtState == ST_RD_ACC);
    stbNext.wrEn    = (nxtState == ST_WR_PULSE);
    // data drive waits out the bus-release window after write enable falls
    stbNext.drive   = (nxtState == ST_WR_PULSE) && (int'(nxtCnt) >= REL_CYC);
  end

  always_comb begin
    cmd.load    = accept;
    cmd.capture = (state == ST_RD_ACC) && lastCyc;
    cmd.done    = ((state == ST_RECOVER) && lastCyc) || (accept && !maskAny);
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && maskAny) |=> !reqReady);

endmodule

// File: rtl/sramCtlPath.sv
module sramCtlPath
  import sramCtlPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stbNext,
  input  pathCmd_t          cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [LANES-1:0]  sramBeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe
);

  logic [LANES-1:0]  maskQ, laneSel;
  logic [DATA_W-1:0] rdMasked;

  assign laneSel = cmd.load ? reqMask : maskQ;

  // Request holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      sramAddr  <= '0;
      sramDqOut <= '0;
    end else if (cmd.load) begin
      maskQ     <= reqMask;
      sramAddr  <= reqAddr;
      sramDqOut <= reqWdata;
    end
  end

  // Registered strobes: each pin comes straight from a flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramCeN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramWeN  <= 1'b1;
      sramDqOe <= 1'b0;
    end else begin
      sramCeN  <= ~stbNext.chipSel;
      sramOeN  <= ~stbNext.outEn;
      sramWeN  <= ~stbNext.wrEn;
      sramDqOe <= stbNext.drive;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sramBeN[ln] <= 1'b1;
      else       sramBeN[ln] <= ~(stbNext.chipSel & laneSel[ln]);
    end
    assign rdMasked[ln*8 +: 8] = maskQ[ln] ? sramDqIn[ln*8 +: 8] : 8'h00;
  end

  // Response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
      rspDone  <= 1'b0;
    end else begin
      rspDone <= cmd.done;
      if (cmd.load)         rspRdata <= '0;
      else if (cmd.capture) rspRdata <= rdMasked;
    end
  end

  p_we_within_ce_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN);

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (!sramWeN && sramOeN));

  p_no_oe_we_overlap_r11: assert property (@(posedge clk) disable iff (!rstN)
    sramOeN || sramWeN);

endmodule

// File: rtl/sramCtl.sv
module sramCtl
  import sramCtlPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 5,
  parameter int T_ADDR_SU_NS = 0,
  parameter int T_WE_PW_NS   = 40,
  parameter int T_AW_NS      = 45,
  parameter int T_DSU_NS     = 25,
  parameter int T_WC_NS      = 55,
  parameter int T_RC_NS      = 55,
  parameter int T_AA_NS      = 55,
  parameter int T_DOE_NS     = 25,
  parameter int T_DBE_NS     = 55,
  parameter int T_RELEASE_NS = 20,
  localparam int LANES       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [LANES-1:0]  sramBeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  strobe_t  stbNext;
  pathCmd_t cmd;

  sramCtlSeq #(
    .LANES(LANES), .CLK_NS(CLK_NS), .T_ADDR_SU_NS(T_ADDR_SU_NS),
    .T_WE_PW_NS(T_WE_PW_NS), .T_AW_NS(T_AW_NS), .T_DSU_NS(T_DSU_NS),
    .T_WC_NS(T_WC_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_DOE_NS(T_DOE_NS), .T_DBE_NS(T_DBE_NS), .T_RELEASE_NS(T_RELEASE_NS)
  ) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .stbNext(stbNext), .cmd(cmd)
  );

  sramCtlPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .stbNext(stbNext), .cmd(cmd),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .sramDqIn(sramDqIn), .rspDone(rspDone), .rspRdata(rspRdata),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramBeN(sramBeN), .sramAddr(sramAddr), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe)
  );

  p_idle_strobes_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCeN && sramOeN && sramWeN && !sramDqOe));

  p_zero_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && (reqMask == '0)) |=> (reqReady && sramCeN && rspDone));

endmodule

// File: tb/sramCtl_test.sv
module sramCtl_test;

  // Phase lengths at a 5 ns clock, taken from the requirements
  localparam int SU  = 1;
  localparam int ACC = 10;
  localparam int PW  = 9;
  localparam int REL = 4;
  localparam int REC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0;
  logic        rspDone;
  logic [15:0] rspRdata;
  logic        sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [1:0]  sramBeN;
  logic [15:0] sramAddr, sramDqOut, sramDqIn;

  always #2.5 clk = ~clk;

  sramCtl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .sramCeN(sramCeN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .sramBeN(sramBeN), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  function automatic logic [15:0] initVal(input int i);
    return 16'(i * 257) ^ 16'h3C00;
  endfunction

  // ---------------- RAM pin model ----------------
  logic [15:0] ram [0:255];
  int          oeLowCnt;
  logic [15:0] ramWord, ramDrv;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) ram[i] <= initVal(i);
      oeLowCnt <= 0;
    end else begin
      if (!sramCeN && !sramOeN && sramWeN) oeLowCnt <= oeLowCnt + 1;
      else                                  oeLowCnt <= 0;
      if (!sramCeN && !sramWeN && sramDqOe) begin
        if (!sramBeN[0]) ram[sramAddr[7:0]][7:0]  <= sramDqOut[7:0];
        if (!sramBeN[1]) ram[sramAddr[7:0]][15:8] <= sramDqOut[15:8];
      end
    end
  end

  always_comb begin
    ramDrv  = 16'h5AC3;
    ramWord = (oeLowCnt >= ACC - 1) ? ram[sramAddr[7:0]] : ~ram[sramAddr[7:0]];
    if (!sramCeN && !sramOeN && sramWeN) begin
      if (!sramBeN[0]) ramDrv[7:0]  = ramWord[7:0];
      if (!sramBeN[1]) ramDrv[15:8] = ramWord[15:8];
    end
  end
  assign sramDqIn = ramDrv;

  // ---------------- reference model ----------------
  typedef struct {
    logic        ceN, oeN, weN, dqOe, ready, done;
    logic [1:0]  beN;
    logic [15:0] addr, wdata, rdata;
    int          tag;
  } exp_t;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic [1:0]  mask;
    logic [15:0] wdata;
    int          gap;
  } req_t;

  exp_t        expQ[$];
  req_t        reqs[$];
  logic [15:0] shadow [0:255];
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  function automatic string tagName(input int t);
    case (t)
      1, 2:    return "R3";
      3:       return "R5";
      4:       return "R8";
      5:       return "R4";
      6:       return "R9";
      7:       return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic exp_t idleExp();
    exp_t e;
    e.ceN = 1; e.oeN = 1; e.weN = 1; e.dqOe = 0; e.ready = 1; e.done = 0;
    e.beN = 2'b11; e.addr = '0; e.wdata = '0; e.rdata = '0; e.tag = 0;
    return e;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(tagName(e.tag), "ceN",  32'(sramCeN),  32'(e.ceN));
    chk(tagName(e.tag), "oeN",  32'(sramOeN),  32'(e.oeN));
    chk(tagName(e.tag), "weN",  32'(sramWeN),  32'(e.weN));
    chk("R7",  "beN",  32'(sramBeN),  32'(e.beN));
    chk("R6",  "dqOe", 32'(sramDqOe), 32'(e.dqOe));
    chk("R2",  "ready", 32'(reqReady), 32'(e.ready));
    chk(tagName(e.tag), "done", 32'(rspDone), 32'(e.done));
    if (!e.ceN)  chk("R3", "addr",  32'(sramAddr),  32'(e.addr));
    if (e.dqOe)  chk("R6", "wdata", 32'(sramDqOut), 32'(e.wdata));
    if (e.done)  chk(tagName(e.tag), "rdata", 32'(rspRdata), 32'(e.rdata));
  endtask

  // Expected pin activity for an accepted request
  task automatic pushTxn(input req_t r);
    exp_t        e;
    logic [15:0] rd;
    if (r.mask == 2'b00) begin
      e = idleExp(); e.done = 1; e.rdata = '0; e.tag = 6;
      expQ.push_back(e);
      return;
    end
    rd = shadow[r.addr[7:0]] & {{8{r.mask[1]}}, {8{r.mask[0]}}};
    for (int i = 0; i < SU; i++) begin
      e = idleExp(); e.ready = 0; e.ceN = 0; e.beN = ~r.mask; e.addr = r.addr; e.tag = 1;
      expQ.push_back(e);
    end
    if (r.wr) begin
      for (int i = 0; i < PW; i++) begin
        e = idleExp(); e.ready = 0; e.ceN = 0; e.weN = 0; e.beN = ~r.mask;
        e.addr = r.addr; e.dqOe = (i >= REL); e.wdata = r.wdata; e.tag = 3;
        expQ.push_back(e);
      end
      if (r.mask[0]) shadow[r.addr[7:0]][7:0]  = r.wdata[7:0];
      if (r.mask[1]) shadow[r.addr[7:0]][15:8] = r.wdata[15:8];
    end else begin
      for (int i = 0; i < ACC; i++) begin
        e = idleExp(); e.ready = 0; e.ceN = 0; e.oeN = 0; e.beN = ~r.mask;
        e.addr = r.addr; e.tag = 2;
        expQ.push_back(e);
      end
    end
    for (int i = 0; i < REC; i++) begin
      e = idleExp(); e.ready = 0; e.tag = 4;
      expQ.push_back(e);
    end
    e = idleExp(); e.done = 1; e.rdata = r.wr ? 16'h0000 : rd; e.tag = r.wr ? 7 : 5;
    expQ.push_back(e);
  endtask

  // One cycle, entered and left at the falling edge
  task automatic stepCycle(input bit hasReq, input req_t r, output bit acc);
    exp_t e;
    reqValid = hasReq;
    reqAddr  = r.addr;
    reqWrite = r.wr;
    reqMask  = r.mask;
    reqWdata = r.wdata;
    e = (expQ.size() > 0) ? expQ.pop_front() : idleExp();
    compare(e);
    acc = hasReq && e.ready;
    if (acc) pushTxn(r);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    req_t idleReq;
    bit   acc;
    idleReq = '{addr: 16'h0, wr: 1'b0, mask: 2'b00, wdata: 16'h0, gap: 0};
    for (int i = 0; i < 256; i++) shadow[i] = initVal(i);

    // Requests: direction, lanes, zero masks, back-to-back
    reqs.push_back('{16'h0010, 1'b1, 2'b11, 16'h1234, 0});
    reqs.push_back('{16'h0010, 1'b0, 2'b11, 16'h0000, 2});
    reqs.push_back('{16'h0010, 1'b1, 2'b01, 16'hABCD, 0});
    reqs.push_back('{16'h0010, 1'b0, 2'b11, 16'h0000, 0});
    reqs.push_back('{16'h0010, 1'b1, 2'b10, 16'h5AFF, 1});
    reqs.push_back('{16'h0010, 1'b0, 2'b01, 16'h0000, 0});
    reqs.push_back('{16'h0010, 1'b0, 2'b10, 16'h0000, 0});
    reqs.push_back('{16'h0020, 1'b1, 2'b00, 16'hFFFF, 0});
    reqs.push_back('{16'h0020, 1'b0, 2'b00, 16'h0000, 0});
    reqs.push_back('{16'h0020, 1'b0, 2'b11, 16'h0000, 0});
    reqs.push_back('{16'h0005, 1'b0, 2'b11, 16'h0000, 0});
    reqs.push_back('{16'h00FF, 1'b1, 2'b11, 16'h8001, 3});
    reqs.push_back('{16'h00FF, 1'b0, 2'b11, 16'h0000, 0});
    reqs.push_back('{16'h0005, 1'b1, 2'b00, 16'h0000, 0});
    reqs.push_back('{16'h0005, 1'b0, 2'b10, 16'h0000, 0});

    // R1: reset state
    repeat (3) @(negedge clk);
    compare(idleExp());
    rstN = 1'b1;
    @(negedge clk);
    compare(idleExp());

    foreach (reqs[k]) begin
      for (int g = 0; g < reqs[k].gap; g++) stepCycle(1'b0, idleReq, acc);
      acc = 1'b0;
      while (!acc) stepCycle(1'b1, reqs[k], acc);
    end
    for (int i = 0; i < 25; i++) stepCycle(1'b0, idleReq, acc);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule